// File: doc/BRIEF.md
# Endpoint Buffer Parallel Access Port

This block is the microcontroller side of a USB peripheral's packet storage. A host processor reaches it over a simple synchronous parallel bus. One address bit sorts each bus cycle into one of two kinds. In a command cycle the processor picks an endpoint packet buffer, or the status byte of one endpoint. In the data cycles that follow, the processor streams a packet into or out of the chosen buffer, one byte at a time on an 8-bit bus or two bytes at a time on a 16-bit bus. Every packet begins with a two-byte little-endian length header, and the same stored packet can be read over either bus width.

There are sixteen endpoints: index 0 is control OUT, index 1 is control IN, and indices 2 to 15 are endpoints 1 to 14. Each endpoint owns one buffer of 66 bytes (a 2-byte header and 64 payload bytes). Endpoints named in a parameter mask also own a second buffer. The byte pointer does no bounds checking. In DMA mode, a double-buffered endpoint rolls from its primary buffer into its secondary buffer. Reading an endpoint's status byte clears that endpoint's interrupt flag. The flags are set by the serial engine and are visible on a port.

Top module: `ep_buf_port`

## Requirements
- R1: A bus write with `bus_cmd` high is a command cycle. It takes its code from `bus_wdata[7:0]`, ignores `bus_wdata[15:8]`, and returns the byte pointer to byte 0 (length low byte) of the primary buffer. Codes 0x00 to 0x1F select the packet buffer of endpoint index code[3:0].
- R2: Codes 0x50 to 0x5F select the status byte of endpoint index code[3:0]. A data read then returns, one cycle later, `{8'h00, status}`, where status bit 7 is the stall flag, bit 1 is set for a double-buffered endpoint, bit 0 is the interrupt flag as it stood before the read, and bits 6:2 are zero.
- R3: A status read clears the interrupt flag of that endpoint at the same clock edge and leaves every other flag unchanged. An interrupt set that arrives in the same cycle wins, and the flag stays set.
- R4: With `bus_wide` low, each data cycle moves one byte at the pointer, and the pointer advances by one. Read data appears on `bus_rdata[7:0]` one cycle after the strobe, with bits 15:8 at zero. The byte order is length low, length high, then data bytes 1 to N.
- R5: With `bus_wide` high, each data cycle moves the byte at the pointer on bits 7:0 and the next byte on bits 15:8, and the pointer advances by two. Word 0 is therefore the whole length, and each later word carries an odd-numbered data byte low and the following even-numbered byte high.
- R6: Past byte 65, the pointer wraps to byte 0 of the same buffer, unless R7 applies. The buffers of other endpoints are never touched.
- R7: With `dma_mode` high on a double-buffered endpoint, the access after byte 65 of the primary buffer goes to byte 0 of the secondary buffer. The secondary buffer wraps onto itself until the next command.
- R8: No direction check is made. Any buffer, including an OUT buffer, can be written, and any buffer can be read back, giving the bytes last written.
- R9: An endpoint's stall flag is set by `sie_stall_set` and cleared by `sie_stall_clr` or `sie_setup_rx`, with set taking priority. Bus cycles never change it.
- R10: After a command code outside both ranges, data writes store nothing, data reads return 0x0000, and the pointer does not move.
- R11: After reset, all interrupt and stall flags are clear, `bus_rdata` is zero and nothing is selected.
- R12: A pulse on `sie_int_set[i]` sets interrupt flag i, which appears on `int_flags` the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cmd | input | 1 | High: command cycle; low: data cycle |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wide | input | 1 | High selects 16-bit data transfers |
| dma_mode | input | 1 | Enables roll-over into the secondary buffer |
| bus_wdata | input | 16 | Write data or command code |
| bus_rdata | output | 16 | Registered read data |
| sie_int_set | input | 16 | Per-endpoint interrupt set pulses |
| sie_stall_set | input | 16 | Per-endpoint stall set |
| sie_stall_clr | input | 16 | Per-endpoint stall clear |
| sie_setup_rx | input | 16 | Per-endpoint SETUP reception, clears stall |
| int_flags | output | 16 | Per-endpoint interrupt flags |

## Verification
Every strobe takes effect at the first rising edge that sees it. The pointer, the stored bytes, the interrupt flag cleared by a status read, and the stall and interrupt flags set by the serial engine all change at that edge. Read data is registered, so it is due one cycle after the read strobe. The bench drives inputs on falling edges, holds each strobe for exactly one cycle, and samples outputs on the next falling edge, which is half a cycle after the edge where every result is due. Each buffer result is checked by reading bytes back through a fresh command, so pointer placement, wrap and roll-over show up only as port data.

// File: rtl/epp_pkg.sv
// Shared types for the endpoint buffer access port.
package epp_pkg;
    // What the last command cycle selected for the following data cycles.
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_BUF  = 2'd1,
        SEL_STAT = 2'd2
    } sel_kind_t;
endpackage

// File: rtl/epp_cmd_decode.sv
// Command decoder: latches the target chosen by a command cycle.
// Assumes the caller qualifies cmd_wr as a write with the command line high.
// Codes naming an endpoint at or above NUM_EP select nothing.
module epp_cmd_decode
    import epp_pkg::*;
#(
    parameter int NUM_EP = 16,
    parameter int EP_W   = $clog2(NUM_EP)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_wr,
    input  logic [7:0]      code,
    output sel_kind_t       sel_kind,
    output logic [EP_W-1:0] sel_ep
);
    sel_kind_t       dec_kind;
    logic [EP_W-1:0] dec_ep;
    logic            ep_ok;

    // Classify the code into buffer, status or nothing.
    always_comb begin
        ep_ok  = ({1'b0, code[3:0]} < 5'(NUM_EP));
        dec_ep = code[EP_W-1:0];
        if (code[7:5] == 3'b000 && ep_ok)
            dec_kind = SEL_BUF;
        else if (code[7:4] == 4'h5 && ep_ok)
            dec_kind = SEL_STAT;
        else
            dec_kind = SEL_NONE;
    end

    // Hold the selection until the next command cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_kind <= SEL_NONE;
            sel_ep   <= '0;
        end else if (cmd_wr) begin
            sel_kind <= dec_kind;
            sel_ep   <= dec_ep;
        end
    end

    a_r1_sel_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_wr |=> ($stable(sel_kind) && $stable(sel_ep)));
    a_r10_reserved_code: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && code[7:5] != 3'b000 && code[7:4] != 4'h5) |=> sel_kind == SEL_NONE);
endmodule

// File: rtl/epp_pointer.sv
// Byte pointer within the selected endpoint's buffer pair.
// Assumes restart and step never both matter in one cycle (restart wins).
// Produces the current address and the address of the following byte,
// so a 16-bit access can touch two bytes across a wrap or roll-over.
module epp_pointer #(
    parameter int BUF_BYTES = 66,
    parameter int PTR_W     = $clog2(BUF_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             step,
    input  logic             wide,
    input  logic             roll_en,
    output logic             bank_q,
    output logic [PTR_W-1:0] ptr_q,
    output logic             bank_b,
    output logic [PTR_W-1:0] ptr_b
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(BUF_BYTES - 1);

    // Next byte address: wrap at the end, moving to bank 1 when rolling.
    function automatic logic [PTR_W:0] adv(input logic [PTR_W:0] cur, input logic roll);
        if (cur[PTR_W-1:0] == LAST)
            return {cur[PTR_W] | roll, {PTR_W{1'b0}}};
        return {cur[PTR_W], cur[PTR_W-1:0] + 1'b1};
    endfunction

    logic [PTR_W:0] nxt1;
    logic [PTR_W:0] nxt2;

    // Addresses one and two bytes ahead of the pointer.
    always_comb begin
        nxt1 = adv({bank_q, ptr_q}, roll_en);
        nxt2 = adv(nxt1, roll_en);
    end

    assign {bank_b, ptr_b} = nxt1;

    // Move the pointer by one or two bytes per access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= 1'b0;
            ptr_q  <= '0;
        end else if (restart) begin
            bank_q <= 1'b0;
            ptr_q  <= '0;
        end else if (step) begin
            {bank_q, ptr_q} <= wide ? nxt2 : nxt1;
        end
    end

    a_r6_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q < PTR_W'(BUF_BYTES));
    a_r1_restart_home: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (ptr_q == '0 && !bank_q));
    a_r7_primary_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!roll_en && !bank_q) |=> !bank_q);
    a_r7_secondary_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_q && !restart) |=> bank_q);
endmodule

// File: rtl/epp_buffer.sv
// Packet storage: two banks of BUF_BYTES per endpoint, byte addressed.
// Two byte lanes so one 16-bit access writes or reads two bytes.
// Storage carries no reset; contents are defined only once written.
module epp_buffer #(
    parameter int NUM_EP    = 16,
    parameter int BUF_BYTES = 66,
    parameter int EP_W      = $clog2(NUM_EP),
    parameter int PTR_W     = $clog2(BUF_BYTES)
) (
    input  logic             clk,
    input  logic             we_lo,
    input  logic             we_hi,
    input  logic [EP_W-1:0]  ep,
    input  logic             bank_a,
    input  logic [PTR_W-1:0] ptr_a,
    input  logic             bank_b,
    input  logic [PTR_W-1:0] ptr_b,
    input  logic [15:0]      wdata,
    output logic [7:0]       rd_a,
    output logic [7:0]       rd_b
);
    localparam int DEPTH  = NUM_EP * 2 * BUF_BYTES;
    localparam int MEM_AW = $clog2(DEPTH);

    logic [7:0] mem [DEPTH];

    // Flat byte index of (endpoint, bank, offset).
    function automatic logic [MEM_AW-1:0] flat(input logic [EP_W-1:0] e,
                                               input logic b,
                                               input logic [PTR_W-1:0] p);
        return MEM_AW'((int'(e) * 2 + int'(b)) * BUF_BYTES + int'(p));
    endfunction

    logic [MEM_AW-1:0] idx_a;
    logic [MEM_AW-1:0] idx_b;

    assign idx_a = flat(ep, bank_a, ptr_a);
    assign idx_b = flat(ep, bank_b, ptr_b);
    assign rd_a  = mem[idx_a];
    assign rd_b  = mem[idx_b];

    // Store the low lane, and the high lane on 16-bit writes.
    always_ff @(posedge clk) begin
        if (we_lo) mem[idx_a] <= wdata[7:0];
        if (we_hi) mem[idx_b] <= wdata[15:8];
    end
endmodule

// File: rtl/epp_status.sv
// Per-endpoint interrupt and stall flags plus the status byte view.
// Assumes rd_clr is a qualified status read of endpoint rd_ep.
module epp_status #(
    parameter int              NUM_EP   = 16,
    parameter int              EP_W     = $clog2(NUM_EP),
    parameter logic [NUM_EP-1:0] DBL_MASK = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EP-1:0] int_set,
    input  logic [NUM_EP-1:0] stall_set,
    input  logic [NUM_EP-1:0] stall_clr,
    input  logic [NUM_EP-1:0] setup_rx,
    input  logic              rd_clr,
    input  logic [EP_W-1:0]   rd_ep,
    output logic [7:0]        status_byte,
    output logic [NUM_EP-1:0] int_q
);
    logic [NUM_EP-1:0] stall_q;
    logic [NUM_EP-1:0] clr_vec;

    assign clr_vec = rd_clr ? (NUM_EP'(1) << rd_ep) : '0;

    // Status byte of the addressed endpoint.
    assign status_byte = {stall_q[rd_ep], 5'b0, DBL_MASK[rd_ep], int_q[rd_ep]};

    // Interrupt flags: read clears, engine sets, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) int_q <= '0;
        else        int_q <= (int_q & ~clr_vec) | int_set;
    end

    // Stall flags: set wins over stall clear and SETUP reception.
    always_ff @(posedge clk) begin
        if (!rst_n) stall_q <= '0;
        else        stall_q <= (stall_q & ~(stall_clr | setup_rx)) | stall_set;
    end

    a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec & ~int_set) != '0 |=> (int_q & $past(clr_vec & ~int_set)) == '0);
    a_r3_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((int_q & ~$past(clr_vec)) & $past(int_q)) == ($past(int_q) & ~$past(clr_vec)));
    a_r12_int_sets: assert property (@(posedge clk) disable iff (!rst_n)
        int_set != '0 |=> (int_q & $past(int_set)) == $past(int_set));
    a_r9_stall_sets: assert property (@(posedge clk) disable iff (!rst_n)
        stall_set != '0 |=> (stall_q & $past(stall_set)) == $past(stall_set));
    a_r9_stall_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ((stall_clr | setup_rx) & ~stall_set) != '0
        |=> (stall_q & $past((stall_clr | setup_rx) & ~stall_set)) == '0);
    a_r9_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_set | stall_clr | setup_rx) == '0 |=> $stable(stall_q));
endmodule

// File: rtl/ep_buf_port.sv
// Parallel bus port into endpoint packet buffers.
// Cycle kinds: bus_cmd high with bus_wr is a command; bus_cmd low with a
// strobe is a data access to whatever the last command selected.
// Assumes single-cycle strobes; a data cycle with both strobes is a write.
module ep_buf_port
    import epp_pkg::*;
#(
    parameter int                NUM_EP        = 16,
    parameter int                PAYLOAD_BYTES = 64,
    parameter logic [NUM_EP-1:0] DBL_MASK      = 16'h0300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cmd,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_wide,
    input  logic              dma_mode,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic [NUM_EP-1:0] sie_int_set,
    input  logic [NUM_EP-1:0] sie_stall_set,
    input  logic [NUM_EP-1:0] sie_stall_clr,
    input  logic [NUM_EP-1:0] sie_setup_rx,
    output logic [NUM_EP-1:0] int_flags
);
    localparam int BUF_BYTES = PAYLOAD_BYTES + 2;
    localparam int EP_W      = $clog2(NUM_EP);
    localparam int PTR_W     = $clog2(BUF_BYTES);

    sel_kind_t        sel_kind;
    logic [EP_W-1:0]  sel_ep;
    logic             cmd_wr;
    logic             data_wr;
    logic             data_rd;
    logic             buf_acc;
    logic             stat_rd;
    logic             roll_en;
    logic             bank_a;
    logic [PTR_W-1:0] ptr_a;
    logic             bank_b;
    logic [PTR_W-1:0] ptr_b;
    logic [7:0]       rd_a;
    logic [7:0]       rd_b;
    logic [7:0]       status_byte;
    logic [15:0]      rdata_q;

    // Qualify the strobes into cycle kinds.
    always_comb begin
        cmd_wr  = bus_cmd && bus_wr;
        data_wr = !bus_cmd && bus_wr;
        data_rd = !bus_cmd && bus_rd && !bus_wr;
        buf_acc = (data_wr || data_rd) && sel_kind == SEL_BUF;
        stat_rd = data_rd && sel_kind == SEL_STAT;
        roll_en = dma_mode && DBL_MASK[sel_ep];
    end

    epp_cmd_decode #(.NUM_EP(NUM_EP), .EP_W(EP_W)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (cmd_wr),
        .code     (bus_wdata[7:0]),
        .sel_kind (sel_kind),
        .sel_ep   (sel_ep)
    );

    epp_pointer #(.BUF_BYTES(BUF_BYTES), .PTR_W(PTR_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (cmd_wr),
        .step    (buf_acc),
        .wide    (bus_wide),
        .roll_en (roll_en),
        .bank_q  (bank_a),
        .ptr_q   (ptr_a),
        .bank_b  (bank_b),
        .ptr_b   (ptr_b)
    );

    epp_buffer #(.NUM_EP(NUM_EP), .BUF_BYTES(BUF_BYTES), .EP_W(EP_W), .PTR_W(PTR_W)) u_buf (
        .clk    (clk),
        .we_lo  (buf_acc && data_wr),
        .we_hi  (buf_acc && data_wr && bus_wide),
        .ep     (sel_ep),
        .bank_a (bank_a),
        .ptr_a  (ptr_a),
        .bank_b (bank_b),
        .ptr_b  (ptr_b),
        .wdata  (bus_wdata),
        .rd_a   (rd_a),
        .rd_b   (rd_b)
    );

    epp_status #(.NUM_EP(NUM_EP), .EP_W(EP_W), .DBL_MASK(DBL_MASK)) u_stat (
        .clk         (clk),
        .rst_n       (rst_n),
        .int_set     (sie_int_set),
        .stall_set   (sie_stall_set),
        .stall_clr   (sie_stall_clr),
        .setup_rx    (sie_setup_rx),
        .rd_clr      (stat_rd),
        .rd_ep       (sel_ep),
        .status_byte (status_byte),
        .int_q       (int_flags)
    );

    // Register read data for the selected target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (data_rd) begin
            case (sel_kind)
                SEL_BUF:  rdata_q <= bus_wide ? {rd_b, rd_a} : {8'h00, rd_a};
                SEL_STAT: rdata_q <= {8'h00, status_byte};
                default:  rdata_q <= '0;
            endcase
        end
    end

    assign bus_rdata = rdata_q;

    a_r10_idle_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && sel_kind == SEL_NONE) |=> bus_rdata == 16'h0000);
    a_r10_idle_ptr_still: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_wr && sel_kind == SEL_NONE) |=> ($stable(ptr_a) && $stable(bank_a)));
    a_r2_status_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && sel_kind == SEL_STAT) |=> bus_rdata[15:8] == 8'h00);
    a_r4_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !bus_wide) |=> bus_rdata[15:8] == 8'h00);
    a_r4_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !data_rd |=> $stable(bus_rdata));
endmodule

// File: tb/ep_buf_port_tb_top.sv
// Directed bench for ep_buf_port: one task per scenario.
module ep_buf_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_cmd = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wide = 1'b0;
    logic        dma_mode = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] int_set = '0;
    logic [15:0] st_set = '0;
    logic [15:0] st_clr = '0;
    logic [15:0] setup = '0;
    logic [15:0] int_flags;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    ep_buf_port dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_cmd       (bus_cmd),
        .bus_wr        (bus_wr),
        .bus_rd        (bus_rd),
        .bus_wide      (bus_wide),
        .dma_mode      (dma_mode),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .sie_int_set   (int_set),
        .sie_stall_set (st_set),
        .sie_stall_clr (st_clr),
        .sie_setup_rx  (setup),
        .int_flags     (int_flags)
    );

    always #5 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: act=%0d cycles exp<=100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic cmd(input logic [15:0] code);
        @(negedge clk);
        bus_cmd = 1'b1; bus_wr = 1'b1; bus_wdata = code;
        @(negedge clk);
        bus_cmd = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wr(input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(output logic [15:0] d);
        @(negedge clk);
        bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse(input int which, input logic [15:0] v);
        @(negedge clk);
        case (which)
            0: int_set = v;
            1: st_set = v;
            2: st_clr = v;
            default: setup = v;
        endcase
        @(negedge clk);
        int_set = '0; st_set = '0; st_clr = '0; setup = '0;
    endtask

    // R11: reset state; R10: read with nothing selected.
    task automatic t_reset;
        logic [15:0] d;
        chk("R11 int_flags", int_flags, 16'h0000);
        chk("R11 rdata", bus_rdata, 16'h0000);
        rd(d);
        chk("R11/R10 read without selection", d, 16'h0000);
    endtask

    // R4, R1, R8: byte stream with the length header first.
    task automatic t_byte_stream;
        logic [15:0] d;
        bus_wide = 1'b0;
        cmd(16'h0003);
        wr(16'h0033);
        cmd(16'h0002);
        wr(16'h0005); wr(16'h0000);
        for (int i = 0; i < 5; i++) wr(16'(8'hA1 + i));
        bus_wide = 1'b1;
        cmd(16'hAB12);            // R1: upper lines ignored, bit4 still ep2
        bus_wide = 1'b0;
        rd(d); chk("R4 length low", d, 16'h0005);
        rd(d); chk("R4 length high", d, 16'h0000);
        for (int i = 0; i < 5; i++) begin
            rd(d); chk("R4 data byte", d, 16'(8'hA1 + i));
        end
        cmd(16'h0002);
        rd(d); chk("R1 new command restarts pointer", d, 16'h0005);
    endtask

    // R5, R8: 16-bit words into the control OUT buffer.
    task automatic t_word_stream;
        logic [15:0] d;
        bus_wide = 1'b1;
        cmd(16'h0000);
        wr(16'h0004); wr(16'hB2B1); wr(16'hB4B3);
        bus_wide = 1'b0;
        cmd(16'h0000);
        rd(d); chk("R5 word0 low is length low", d, 16'h0004);
        rd(d); chk("R5 word0 high is length high", d, 16'h0000);
        rd(d); chk("R5 data byte1 in low lane", d, 16'h00B1);
        rd(d); chk("R8 data byte2 in high lane", d, 16'h00B2);
        bus_wide = 1'b1;
        cmd(16'h0010);
        rd(d); chk("R5 wide length word", d, 16'h0004);
        rd(d); chk("R5 wide data word", d, 16'hB2B1);
        rd(d); chk("R5 wide data word 2", d, 16'hB4B3);
        bus_wide = 1'b0;
    endtask

    // R6: wrap inside one buffer, neighbours untouched.
    task automatic t_wrap;
        logic [15:0] d;
        cmd(16'h0004);
        for (int i = 0; i < 66; i++) wr(16'(i));
        wr(16'h00EE);
        cmd(16'h0004);
        rd(d); chk("R6 wrapped write lands on byte 0", d, 16'h00EE);
        rd(d); chk("R6 byte 1 kept", d, 16'h0001);
        cmd(16'h0003);
        rd(d); chk("R6 other endpoint untouched", d, 16'h0033);
        cmd(16'h0005);
        dma_mode = 1'b1;
        for (int i = 0; i < 66; i++) wr(16'h0011);
        wr(16'h0077);
        cmd(16'h0005);
        rd(d); chk("R6 single buffer wraps even in DMA mode", d, 16'h0077);
        dma_mode = 1'b0;
    endtask

    // R7: roll-over into the secondary buffer in DMA mode.
    task automatic t_dma;
        logic [15:0] d;
        dma_mode = 1'b1;
        cmd(16'h0008);
        for (int i = 0; i < 66; i++) wr(16'(i ^ 8'h5A));
        wr(16'h00C1); wr(16'h00C2);
        dma_mode = 1'b0;
        cmd(16'h0008);
        rd(d); chk("R7 primary byte 0 not overwritten", d, 16'h005A);
        dma_mode = 1'b1;
        cmd(16'h0008);
        for (int i = 0; i < 66; i++) rd(d);
        rd(d); chk("R7 secondary byte 0", d, 16'h00C1);
        rd(d); chk("R7 secondary byte 1", d, 16'h00C2);
        dma_mode = 1'b0;
        cmd(16'h0008);
        for (int i = 0; i < 66; i++) wr(16'h0000);
        wr(16'h0099);
        cmd(16'h0008);
        rd(d); chk("R6 double-buffered wraps without DMA", d, 16'h0099);
    endtask

    // R2, R3, R9, R12: status bytes and flag handling.
    task automatic t_status;
        logic [15:0] d;
        pulse(0, 16'h0210);
        chk("R12 interrupt flags set", int_flags, 16'h0210);
        cmd(16'h0054);
        rd(d);
        chk("R2 status of ep4", d, 16'h0001);
        chk("R3 read clears only ep4", int_flags, 16'h0200);
        rd(d);
        chk("R3 second read sees clear flag", d, 16'h0000);
        pulse(1, 16'h0200);
        cmd(16'h0059);
        rd(d);
        chk("R2 stall, double-buffer and interrupt bits", d, 16'h0083);
        chk("R3 ep9 flag cleared", int_flags, 16'h0000);
        @(negedge clk);
        bus_rd = 1'b1; int_set = 16'h0200;
        @(negedge clk);
        bus_rd = 1'b0; int_set = '0;
        chk("R3 set wins over read clear", int_flags, 16'h0200);
        @(negedge clk);
        st_set = 16'h0200; st_clr = 16'h0200;
        @(negedge clk);
        st_set = '0; st_clr = '0;
        rd(d);
        chk("R9 stall set wins over clear", d, 16'h0083);
        pulse(3, 16'h0200);
        rd(d);
        chk("R9 SETUP clears stall", d, 16'h0002);
        pulse(1, 16'h0200);
        pulse(2, 16'h0200);
        rd(d);
        chk("R9 stall clear", d, 16'h0002);
        pulse(1, 16'h0200);
        cmd(16'h0009);
        wr(16'h00FF);
        cmd(16'h0059);
        rd(d);
        chk("R9 bus writes leave stall alone", d, 16'h0082);
    endtask

    // R10: reserved codes select nothing.
    task automatic t_reserved;
        logic [15:0] d;
        cmd(16'h0030);
        wr(16'h0066);
        rd(d);
        chk("R10 read after reserved code", d, 16'h0000);
        cmd(16'h0002);
        rd(d);
        chk("R10 no write reached ep2", d, 16'h0005);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_byte_stream();
        t_word_stream();
        t_wrap();
        t_dma();
        t_status();
        t_reserved();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule